// File: doc/BRIEF.md
# Power-Fail Store/Recall Controller

This block sequences a volatile working memory against its nonvolatile shadow copy as the supply rises and falls. It watches two digital comparator flags: one that is high while the supply sits above the switch threshold, and one that is high while the supply is below the lower reset threshold. It also watches the write strobe of the memory port. From these it issues one-cycle store and recall command pulses, holds a busy flag while a transfer runs, and gates writes at the memory port.

A store is worth its cost only when the working copy differs from the shadow. The controller therefore tracks whether any write has been accepted since the last transfer, and on a supply drop it stores only in that case. A store waits a short grace period first, so that an access already under way can finish. A recall is armed only by a deep drop below the reset threshold, which includes initial power-up. A shallow brown-out that stays above the reset threshold never leads to a recall. The store, recall and grace durations are parameters counted in clock cycles.

Top module: `pwr_xfer_ctrl`

## Requirements
- R1: When the switch flag falls and at least one write has been accepted since the last completed transfer, a store starts. When no such write has occurred, no store pulse is issued.
- R2: A recall request is latched in every cycle that the reset flag is high, and also by reset. It stays latched until a recall completes.
- R3: In the first clock edge at which the switch flag is high with a recall latched, a recall pulse is issued. Busy then stays high for exactly RESTORE_CYC cycles, starting with the pulse cycle.
- R4: A supply dip that clears the switch flag but never raises the reset flag causes no recall when the supply returns.
- R5: For a store, busy is high for GRACE_CYC + STORE_CYC consecutive cycles, covering both the grace period and the store.
- R6: The store pulse appears GRACE_CYC + 1 cycles after the first cycle in which the switch flag is sampled low.
- R7: The write-inhibit output is high whenever the switch flag is low, the reset flag is high, or busy is high.
- R8: The written-since-transfer state is cleared when a store or a recall completes, and is set by every accepted write.
- R9: Write strobes that arrive while write-inhibit is high do not count as writes.
- R10: The reset flag is checked ahead of the switch flag. If it rises during a grace period or a store, busy drops at the next edge, the store does not complete, and a recall is latched.
- R11: Each command pulse lasts exactly one cycle, and store and recall pulses never coincide.
- R12: If the switch flag falls during a recall, the recall is abandoned (busy drops at the next edge). A new full recall starts when the flag returns.
- R13: During reset, busy and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and state clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vok_i | input | 1 | High while supply is above the switch threshold |
| vlow_i | input | 1 | High while supply is below the reset threshold |
| wr_strobe_i | input | 1 | One pulse per write seen at the memory port |
| store_pulse_o | output | 1 | One-cycle command starting a store |
| recall_pulse_o | output | 1 | One-cycle command starting a recall |
| busy_o | output | 1 | High during grace, store and recall |
| wr_inhibit_o | output | 1 | Blocks writes at the memory port |

## Verification
The bench targets several corner cases:
- A dip with no prior writes: a design that ignores the written-since-transfer state would issue a needless store.
- A shallow brown-out right after a store: a design that arms recall on any dip would overwrite fresh data with a recall.
- A reset-level collapse in the middle of a store: a design lacking the priority would run the store to completion and leave no recall latched.
- A supply dip during a recall: a design that keeps the recall alive, or forgets the request, would return with stale or half-restored contents.
- Writes strobed while inhibited, both below the threshold and during a recall: a design that lets them mark the data changed would store on the next dip.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_GRACE  = 3'd1,
    ST_STORE  = 3'd2,
    ST_RECALL = 3'd3,
    ST_DOWN   = 3'd4
  } pfc_state_e;

  // states in which the controller owns the memory
  function automatic logic is_busy(input pfc_state_e st);
    return (st == ST_GRACE) || (st == ST_STORE) || (st == ST_RECALL);
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // counter width able to hold a duration of dur cycles
  function automatic int dur_width(input int dur);
    return (dur < 2) ? 1 : $clog2(dur + 1);
  endfunction

endpackage

// File: rtl/pfc_timer.sv
module pfc_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (ld_i)           cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pfc_flags.sv
module pfc_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ok_i,
  input  logic low_i,
  input  logic store_done_i,
  input  logic recall_done_i,
  output logic dirty_o,
  output logic pend_o
);

  // written-since-transfer: cleared by any completed transfer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            dirty_o <= 1'b0;
    else if (store_done_i || recall_done_i) dirty_o <= 1'b0;
    else if (wr_ok_i)                      dirty_o <= 1'b1;
  end

  // recall request: power-up counts as a deep drop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pend_o <= 1'b1;
    else if (low_i)         pend_o <= 1'b1;
    else if (recall_done_i) pend_o <= 1'b0;
  end

endmodule

// File: rtl/pfc_seq.sv
module pfc_seq
  import pfc_pkg::*;
#(
  parameter int GRACE_CYC   = 4,
  parameter int STORE_CYC   = 40,
  parameter int RESTORE_CYC = 20,
  parameter int CW          = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vok_i,
  input  logic          vlow_i,
  input  logic          dirty_i,
  input  logic          pend_i,
  input  logic          tmr_zero_i,
  output pfc_state_e    st_o,
  output logic          ld_o,
  output logic [CW-1:0] ld_val_o,
  output logic          store_pulse_o,
  output logic          recall_pulse_o,
  output logic          store_done_o,
  output logic          recall_done_o
);

  localparam logic [CW-1:0] GRACE_LD   = CW'(GRACE_CYC - 1);
  localparam logic [CW-1:0] STORE_LD   = CW'(STORE_CYC - 1);
  localparam logic [CW-1:0] RESTORE_LD = CW'(RESTORE_CYC - 1);

  pfc_state_e st_q, st_d;

  always_comb begin
    st_d          = st_q;
    ld_o          = 1'b0;
    ld_val_o      = '0;
    store_done_o  = 1'b0;
    recall_done_o = 1'b0;
    if (vlow_i) begin
      // deep collapse wins over everything, aborts any transfer
      st_d = ST_DOWN;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (!vok_i) begin
            if (dirty_i) begin
              st_d     = ST_GRACE;
              ld_o     = 1'b1;
              ld_val_o = GRACE_LD;
            end else begin
              st_d = ST_DOWN;
            end
          end
        end
        ST_GRACE: begin
          if (tmr_zero_i) begin
            st_d     = ST_STORE;
            ld_o     = 1'b1;
            ld_val_o = STORE_LD;
          end
        end
        ST_STORE: begin
          if (tmr_zero_i) begin
            store_done_o = 1'b1;
            st_d         = vok_i ? ST_IDLE : ST_DOWN;
          end
        end
        ST_RECALL: begin
          if (!vok_i) begin
            st_d = ST_DOWN;
          end else if (tmr_zero_i) begin
            recall_done_o = 1'b1;
            st_d          = ST_IDLE;
          end
        end
        ST_DOWN: begin
          if (vok_i) begin
            if (pend_i) begin
              st_d     = ST_RECALL;
              ld_o     = 1'b1;
              ld_val_o = RESTORE_LD;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: st_d = ST_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q           <= ST_DOWN;
      store_pulse_o  <= 1'b0;
      recall_pulse_o <= 1'b0;
    end else begin
      st_q           <= st_d;
      store_pulse_o  <= (st_d == ST_STORE)  && (st_q != ST_STORE);
      recall_pulse_o <= (st_d == ST_RECALL) && (st_q != ST_RECALL);
    end
  end

  assign st_o = st_q;

endmodule

// File: rtl/pwr_xfer_ctrl.sv
module pwr_xfer_ctrl
  import pfc_pkg::*;
#(
  parameter int GRACE_CYC   = 4,
  parameter int STORE_CYC   = 40,
  parameter int RESTORE_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vok_i,
  input  logic vlow_i,
  input  logic wr_strobe_i,
  output logic store_pulse_o,
  output logic recall_pulse_o,
  output logic busy_o,
  output logic wr_inhibit_o
);

  localparam int MAX_DUR = max3(GRACE_CYC, STORE_CYC, RESTORE_CYC);
  localparam int CW      = dur_width(MAX_DUR);

  pfc_state_e    st;
  logic          ld;
  logic [CW-1:0] ld_val;
  logic          tmr_zero;
  logic          dirty;
  logic          rpend;
  logic          wr_ok;
  logic          ev_store_done;
  logic          ev_recall_done;

  assign busy_o       = is_busy(st);
  assign wr_inhibit_o = !vok_i || vlow_i || busy_o;
  assign wr_ok        = wr_strobe_i && !wr_inhibit_o;

  pfc_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_i   (ld),
    .val_i  (ld_val),
    .zero_o (tmr_zero)
  );

  pfc_flags u_flags (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_ok_i       (wr_ok),
    .low_i         (vlow_i),
    .store_done_i  (ev_store_done),
    .recall_done_i (ev_recall_done),
    .dirty_o       (dirty),
    .pend_o        (rpend)
  );

  pfc_seq #(
    .GRACE_CYC   (GRACE_CYC),
    .STORE_CYC   (STORE_CYC),
    .RESTORE_CYC (RESTORE_CYC),
    .CW          (CW)
  ) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .vok_i          (vok_i),
    .vlow_i         (vlow_i),
    .dirty_i        (dirty),
    .pend_i         (rpend),
    .tmr_zero_i     (tmr_zero),
    .st_o           (st),
    .ld_o           (ld),
    .ld_val_o       (ld_val),
    .store_pulse_o  (store_pulse_o),
    .recall_pulse_o (recall_pulse_o),
    .store_done_o   (ev_store_done),
    .recall_done_o  (ev_recall_done)
  );

endmodule

// File: rtl/pfc_chk.sv
module pfc_chk #(
  parameter int STORE_CYC = 40
) (
  input logic clk,
  input logic rst_n,
  input logic vlow_i,
  input logic wr_strobe_i,
  input logic store_pulse_o,
  input logic recall_pulse_o,
  input logic busy_o,
  input logic wr_inhibit_o,
  input logic dirty,
  input logic rpend,
  input logic ev_store_done,
  input logic ev_recall_done
);

  int unsigned run_q;
  int unsigned run_d;

  // cycles since the store pulse, the pulse cycle counted as one
  assign run_d = store_pulse_o ? 32'd1 : run_q + 32'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assert_store_needs_dirty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    store_pulse_o |-> dirty);

  assert_low_latches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vlow_i |=> rpend);

  assert_recall_needs_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    recall_pulse_o |-> rpend);

  assert_store_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_store_done |-> (busy_o && run_d == STORE_CYC));

  assert_inhibit_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe_i && wr_inhibit_o && !ev_store_done && !ev_recall_done)
      |=> (dirty == $past(dirty)));

  assert_collapse_aborts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vlow_i && busy_o) |=> !busy_o);

  assert_pulse_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({store_pulse_o, recall_pulse_o}));

  assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (store_pulse_o || recall_pulse_o) |=> !(store_pulse_o || recall_pulse_o));

endmodule

bind pwr_xfer_ctrl pfc_chk #(.STORE_CYC(STORE_CYC)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .vlow_i         (vlow_i),
  .wr_strobe_i    (wr_strobe_i),
  .store_pulse_o  (store_pulse_o),
  .recall_pulse_o (recall_pulse_o),
  .busy_o         (busy_o),
  .wr_inhibit_o   (wr_inhibit_o),
  .dirty          (dirty),
  .rpend          (rpend),
  .ev_store_done  (ev_store_done),
  .ev_recall_done (ev_recall_done)
);

// File: tb/pwr_xfer_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_xfer_ctrl_tb;

  localparam int GRACE   = 4;
  localparam int STORE   = 40;
  localparam int RESTORE = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vok = 1'b0;
  logic vlow = 1'b1;
  logic wr = 1'b0;
  logic sp, rp, busy, inh;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int sp_cnt = 0, rp_cnt = 0, sp_cyc = 0;
  int run = 0, last_run = 0;
  int c0;

  always #5 clk = ~clk;

  pwr_xfer_ctrl #(.GRACE_CYC(GRACE), .STORE_CYC(STORE), .RESTORE_CYC(RESTORE)) u_dut (
    .clk(clk), .rst_n(rst_n), .vok_i(vok), .vlow_i(vlow), .wr_strobe_i(wr),
    .store_pulse_o(sp), .recall_pulse_o(rp), .busy_o(busy), .wr_inhibit_o(inh)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model: phase 0 idle, 1 grace, 2 store, 3 recall, 4 down
  int m_phase = 4, m_left = 0;
  bit m_dirty = 0, m_pend = 1, m_sp = 0, m_rp = 0;
  bit m_busy;
  assign m_busy = (m_phase >= 1 && m_phase <= 3);

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 4; m_pend = 1; m_dirty = 0; m_sp = 0; m_rp = 0; m_left = 0;
    end else begin
      bit acc;
      acc = wr && vok && !vlow && !m_busy;
      m_sp = 0; m_rp = 0;
      if (vlow) begin
        m_pend = 1; m_phase = 4;
      end else begin
        case (m_phase)
          0: if (!vok) begin
               if (m_dirty) begin m_phase = 1; m_left = GRACE; end
               else m_phase = 4;
             end
          1: begin
               m_left--;
               if (m_left == 0) begin m_phase = 2; m_left = STORE; m_sp = 1; end
             end
          2: begin
               m_left--;
               if (m_left == 0) begin m_dirty = 0; m_phase = vok ? 0 : 4; end
             end
          3: if (!vok) m_phase = 4;
             else begin
               m_left--;
               if (m_left == 0) begin m_dirty = 0; m_pend = 0; m_phase = 0; end
             end
          default: if (vok) begin
               if (m_pend) begin m_phase = 3; m_left = RESTORE; m_rp = 1; end
               else m_phase = 0;
             end
        endcase
      end
      if (acc) m_dirty = 1;
    end
  end

  // per-cycle compare and event recording, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R1 R11 store pulse vs model", sp, m_sp);
      chk("R3 R11 recall pulse vs model", rp, m_rp);
      chk("R5 busy vs model", busy, m_busy);
      chk("R7 inhibit vs model", inh, (!vok || vlow || m_busy));
      if (sp) begin sp_cnt++; sp_cyc = cyc; end
      if (rp) rp_cnt++;
      if (busy) run++;
      else if (run > 0) begin last_run = run; run = 0; end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic write1();
    wr = 1'b1; tick(1); wr = 1'b0;
  endtask

  initial begin : watchdog
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tick(3);
    chk("R13 busy in reset", busy, 0);
    chk("R13 store pulse in reset", sp, 0);
    chk("R13 recall pulse in reset", rp, 0);
    rst_n = 1'b1; tick(2);
    vlow = 1'b0; tick(2);
    vok = 1'b1; tick(RESTORE + 3);
    chk("R2 R3 power-up recall count", rp_cnt, 1);
    chk("R3 recall busy length", last_run, RESTORE);

    // no writes: dip causes neither store nor recall
    vok = 1'b0; tick(10);
    chk("R1 no store without writes", sp_cnt, 0);
    vok = 1'b1; tick(5);
    chk("R4 no recall after clean dip", rp_cnt, 1);

    // write then dip: store after grace
    write1(); tick(2);
    vok = 1'b0; c0 = cyc;
    tick(GRACE + STORE + 5);
    chk("R1 store after write", sp_cnt, 1);
    chk("R6 grace delay to store pulse", sp_cyc - c0, GRACE + 1);
    chk("R5 store busy length", last_run, GRACE + STORE);
    chk("R7 inhibit while supply low", inh, 1);
    write1(); tick(2);
    vok = 1'b1; tick(5);
    chk("R4 brown-out gives no recall", rp_cnt, 1);
    vok = 1'b0; tick(10);
    chk("R9 R8 inhibited write left no store", sp_cnt, 1);
    vok = 1'b1; tick(3);

    // collapse during store
    write1(); tick(1);
    vok = 1'b0; tick(GRACE + 5);
    chk("R10 store running", busy, 1);
    vlow = 1'b1; tick(1);
    chk("R10 collapse aborts store", busy, 0);
    chk("R10 store pulse count", sp_cnt, 2);
    vlow = 1'b0; tick(3);
    vok = 1'b1; tick(RESTORE + 3);
    chk("R10 R2 recall after collapse", rp_cnt, 2);
    vok = 1'b0; tick(10);
    chk("R8 recall cleared written state", sp_cnt, 2);
    vok = 1'b1; tick(3);

    // dip during recall, write during recall
    vok = 1'b0; vlow = 1'b1; tick(2);
    vlow = 1'b0; vok = 1'b1; tick(5);
    chk("R7 inhibit while busy", inh, 1);
    write1();
    vok = 1'b0; tick(1);
    chk("R12 dip abandons recall", busy, 0);
    tick(3);
    vok = 1'b1; tick(RESTORE + 3);
    chk("R12 recall restarted", rp_cnt, 4);
    chk("R12 full restart length", last_run, RESTORE);
    vok = 1'b0; tick(10);
    chk("R9 write during recall ignored", sp_cnt, 2);
    vok = 1'b1; tick(3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule